// File: doc/BRIEF.md
# Masked Vector Find-First-Set Unit

This block scans a vector mask register for the lowest-numbered active element whose mask bit is set, and returns that element's index as a signed scalar. An element is active when its index is below the active vector length and either predication is off or the predicate mask bit for that element is 1. Each element's bit sits at a stride given by the mask spacing, `2**mlen_log2` bits apart, in both masks. When no active element has its bit set, the result is all ones, which reads as -1.

The block decodes the instruction word itself. It exposes the source vector register number so that an outer register file can supply `src_mask`. The predicate is always read from vector register 0 and is fed on `pred_mask`. The scan is combinational. The result and the destination scalar register number are captured one clock after a recognised `start`, together with a one-cycle `done` strobe.

Top module: `vmask_first_unit`

## Requirements
- R1: An operation is accepted only when `start` is 1 and the instruction has bits [31:26] = 010101, bits [14:12] = 010 and bits [6:0] = 1010111. Bits [19:15] are ignored. A `start` with any other instruction produces no `done`.
- R2: `done` is 1 in exactly the cycle after an accepted `start`, and 0 otherwise.
- R3: Element e of both masks is bit e·2^`mlen_log2` of the mask vector. An element whose position falls at or beyond VLEN counts as clear.
- R4: Elements with index at or above `vl` are ignored even when their bits are set.
- R5: Instruction bit 25 = 1 makes every element below `vl` active. Bit 25 = 0 makes element e active only when its `pred_mask` bit is 1.
- R6: `result` is the smallest active element index whose `src_mask` bit is 1, zero-extended to XLEN bits.
- R7: When no active element has its source bit set, including the case `vl` = 0, `result` is all ones.
- R8: `dest_reg` takes instruction bits [11:7] together with `result`. `src_vreg` equals instruction bits [24:20] combinationally.
- R9: `result` and `dest_reg` keep their values in every cycle that does not follow an accepted `start`.
- R10: After reset, `done`, `result` and `dest_reg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute `insn` |
| insn | input | 32 | Instruction word |
| vl | input | $clog2(VLEN+1) | Active vector length in elements |
| mlen_log2 | input | $clog2(MLOG+1) | Log2 of the mask bit spacing |
| src_mask | input | VLEN | Source mask register contents |
| pred_mask | input | VLEN | Predicate mask (vector register 0) |
| src_vreg | output | 5 | Source vector register number |
| done | output | 1 | Result valid strobe |
| result | output | XLEN | Element index or all ones |
| dest_reg | output | 5 | Destination scalar register number |

## Verification
`src_vreg` is due in the same cycle the instruction is applied. `done`, `result` and `dest_reg` are due on the first rising edge after an accepted `start`. The bench drives inputs on the falling edge and raises `start` for one cycle. It samples the registered outputs on the next falling edge, then one cycle later, to confirm that `done` has dropped and the values are held. Every mask spacing, every vector length up to the element count, and both predication settings are swept with random masks against an arithmetic reference scan.

// File: rtl/vff_pkg.sv
package vff_pkg;
    localparam logic [5:0] FFS_FUNCT6 = 6'b010101;
    localparam logic [2:0] FFS_FUNCT3 = 3'b010;
    localparam logic [6:0] FFS_OPCODE = 7'b1010111;

    typedef struct packed {
        logic       hit;
        logic       unmasked;
        logic [4:0] rd;
        logic [4:0] rs2;
    } op_fields_t;
endpackage

// File: rtl/vff_decode.sv
module vff_decode
    import vff_pkg::*;
(
    input  logic [31:0] insn,
    output op_fields_t  fields
);
    always_comb begin
        fields.hit      = (insn[31:26] == FFS_FUNCT6) &&
                          (insn[14:12] == FFS_FUNCT3) &&
                          (insn[6:0]   == FFS_OPCODE);
        fields.unmasked = insn[25];
        fields.rd       = insn[11:7];
        fields.rs2      = insn[24:20];
    end
endmodule

// File: rtl/vff_qualify.sv
module vff_qualify #(
    parameter int VLEN = 128,
    parameter int MLOG = 6,
    localparam int NE  = VLEN,
    localparam int VLW = $clog2(VLEN + 1),
    localparam int MW  = $clog2(MLOG + 1)
) (
    input  logic [VLEN-1:0] src_mask,
    input  logic [VLEN-1:0] pred_mask,
    input  logic [VLW-1:0]  vl,
    input  logic [MW-1:0]   mlen_log2,
    input  logic            unmasked,
    output logic [NE-1:0]   qual
);
    for (genvar e = 0; e < NE; e++) begin : g_elem
        logic [MLOG:0] src_c;
        logic [MLOG:0] pred_c;
        logic          src_bit;
        logic          pred_bit;
        localparam logic [VLW-1:0] EIDX = VLW'(e);

        for (genvar k = 0; k <= MLOG; k++) begin : g_stride
            if (e * (2 ** k) < VLEN) begin : g_in
                assign src_c[k]  = src_mask[e * (2 ** k)];
                assign pred_c[k] = pred_mask[e * (2 ** k)];
            end else begin : g_out
                assign src_c[k]  = 1'b0;
                assign pred_c[k] = 1'b0;
            end
        end

        always_comb begin
            src_bit  = 1'b0;
            pred_bit = 1'b0;
            if (int'(mlen_log2) <= MLOG) begin
                src_bit  = src_c[mlen_log2];
                pred_bit = pred_c[mlen_log2];
            end
        end

        assign qual[e] = (EIDX < vl) && src_bit && (unmasked || pred_bit);
    end
endmodule

// File: rtl/vff_first.sv
module vff_first #(
    parameter int NE = 128,
    localparam int IW = $clog2(NE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] qual,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |qual;
        idx   = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (qual[i]) idx = IW'(i);
        end
    end

    assert_hit_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> qual[idx]);

    assert_nothing_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((qual & ((NE'(1) << idx) - NE'(1))) == '0));
endmodule

// File: rtl/vmask_first_unit.sv
module vmask_first_unit
    import vff_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int MLOG = 6,
    parameter int XLEN = 64,
    localparam int NE  = VLEN,
    localparam int IW  = $clog2(NE),
    localparam int VLW = $clog2(VLEN + 1),
    localparam int MW  = $clog2(MLOG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     insn,
    input  logic [VLW-1:0]  vl,
    input  logic [MW-1:0]   mlen_log2,
    input  logic [VLEN-1:0] src_mask,
    input  logic [VLEN-1:0] pred_mask,
    output logic [4:0]      src_vreg,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [4:0]      dest_reg
);
    typedef struct packed {
        logic            done;
        logic [XLEN-1:0] result;
        logic [4:0]      rd;
    } state_t;

    op_fields_t      fields;
    logic [NE-1:0]   qual;
    logic            found;
    logic [IW-1:0]   idx;
    logic            accept;
    state_t          state_d, state_q;

    vff_decode u_decode (
        .insn   (insn),
        .fields (fields)
    );

    vff_qualify #(.VLEN(VLEN), .MLOG(MLOG)) u_qualify (
        .src_mask  (src_mask),
        .pred_mask (pred_mask),
        .vl        (vl),
        .mlen_log2 (mlen_log2),
        .unmasked  (fields.unmasked),
        .qual      (qual)
    );

    vff_first #(.NE(NE)) u_first (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual),
        .found (found),
        .idx   (idx)
    );

    assign accept = start && fields.hit;

    always_comb begin
        state_d      = state_q;
        state_d.done = accept;
        if (accept) begin
            state_d.result = found ? XLEN'(idx) : '1;
            state_d.rd     = fields.rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign src_vreg = fields.rs2;
    assign done     = state_q.done;
    assign result   = state_q.result;
    assign dest_reg = state_q.rd;

    assert_done_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && insn[31:26] == 6'b010101 && insn[14:12] == 3'b010 &&
         insn[6:0] == 7'b1010111) |=> done);

    assert_no_done_on_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && fields.hit) |=> !done);

    assert_empty_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vl == '0) |=> (result == '1));

    assert_index_below_vl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != '1) |-> (result < XLEN'($past(vl))));

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(dest_reg)));
endmodule

// File: tb/vmask_first_unit_bench.sv
module vmask_first_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 16;
    localparam int MLOG = 4;
    localparam int XLEN = 16;
    localparam int VLW  = $clog2(VLEN + 1);
    localparam int MW   = $clog2(MLOG + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     insn = '0;
    logic [VLW-1:0]  vl = '0;
    logic [MW-1:0]   mlen_log2 = '0;
    logic [VLEN-1:0] src_mask = '0;
    logic [VLEN-1:0] pred_mask = '0;
    logic [4:0]      src_vreg;
    logic            done;
    logic [XLEN-1:0] result;
    logic [4:0]      dest_reg;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vmask_first_unit #(.VLEN(VLEN), .MLOG(MLOG), .XLEN(XLEN)) u_vmask_first_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .vl(vl),
        .mlen_log2(mlen_log2), .src_mask(src_mask), .pred_mask(pred_mask),
        .src_vreg(src_vreg), .done(done), .result(result), .dest_reg(dest_reg)
    );

    function automatic logic [31:0] mk(input logic vm, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [4:0] rd);
        return {6'b010101, vm, rs2, rs1, 3'b010, rd, 7'b1010111};
    endfunction

    function automatic logic [XLEN-1:0] ref_first(input logic [VLEN-1:0] s,
            input logic [VLEN-1:0] p, input int len, input int m, input logic vm);
        for (int e = 0; e < VLEN; e++) begin
            int pos = e * (1 << m);
            if (e < len && pos < VLEN && (vm || p[pos]) && s[pos]) return XLEN'(e);
        end
        return '1;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [VLEN-1:0] s,
                          input logic [VLEN-1:0] p, input int len, input int m,
                          input string req);
        logic [XLEN-1:0] exp;
        exp = ref_first(s, p, len, m, w[25]);
        insn = w; src_mask = s; pred_mask = p; vl = VLW'(len); mlen_log2 = MW'(m);
        start = 1'b1;
        #1 chk("R8 src_vreg", XLEN'(src_vreg), XLEN'(w[24:20]));
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk({req, " done R2"}, XLEN'(done), 1);
        chk(req, result, exp);
        chk("R8 dest_reg", XLEN'(dest_reg), XLEN'(w[11:7]));
        @(posedge clk); @(negedge clk);
        chk("R2 done single", XLEN'(done), 0);
        chk("R9 result held", result, exp);
    endtask

    task automatic reject(input logic [31:0] w, input string req);
        logic [XLEN-1:0] prev_r;
        logic [4:0]      prev_d;
        prev_r = result; prev_d = dest_reg;
        insn = w; src_mask = '1; pred_mask = '1; vl = VLW'(VLEN); mlen_log2 = '0;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk({req, " no done"}, XLEN'(done), 0);
        chk("R9 result held", result, prev_r);
        chk("R9 dest held", XLEN'(dest_reg), XLEN'(prev_d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 done reset", XLEN'(done), 0);
        chk("R10 result reset", result, 0);
        chk("R10 dest reset", XLEN'(dest_reg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: decode fields must all match; rs1 ignored
        run_op(mk(1'b1, 5'd3, 5'd31, 5'd9), 16'h0040, '0, 16, 0, "R1 rs1 ignored R6");
        reject({6'b010100, mk(1'b1, 5'd3, 5'd0, 5'd4)[25:0]}, "R1 funct6");
        reject({mk(1'b1, 5'd3, 5'd0, 5'd4)[31:15], 3'b011, mk(1'b1, 5'd3, 5'd0, 5'd4)[11:0]}, "R1 funct3");
        reject({mk(1'b1, 5'd3, 5'd0, 5'd4)[31:7], 7'b1010011}, "R1 opcode");
        // R9: start low leaves state alone
        insn = mk(1'b1, 5'd1, 5'd0, 5'd2); start = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 idle result", result, 16'd6);

        // R7: empty length and empty mask
        run_op(mk(1'b1, 5'd1, 5'd0, 5'd5), '1, '1, 0, 0, "R7 vl zero");
        run_op(mk(1'b1, 5'd1, 5'd0, 5'd5), '0, '1, 16, 0, "R7 no bits");
        // R4: only bit beyond vl
        run_op(mk(1'b1, 5'd1, 5'd0, 5'd6), 16'h0100, '0, 8, 0, "R4 beyond vl");
        run_op(mk(1'b1, 5'd1, 5'd0, 5'd6), 16'h0100, '0, 9, 0, "R4 last active");
        // R5: predicate gating
        run_op(mk(1'b0, 5'd2, 5'd0, 5'd7), 16'h0006, 16'h0004, 16, 0, "R5 predicated");
        run_op(mk(1'b1, 5'd2, 5'd0, 5'd7), 16'h0006, 16'h0004, 16, 0, "R5 unmasked");
        // R3: stride placement
        run_op(mk(1'b1, 5'd2, 5'd0, 5'd8), 16'h0002, '0, 16, 1, "R3 off-stride bit");
        run_op(mk(1'b1, 5'd2, 5'd0, 5'd8), 16'h0030, '0, 16, 2, "R3 stride four");
        run_op(mk(1'b1, 5'd2, 5'd0, 5'd8), 16'h0001, '0, 16, 4, "R3 single element");

        // sweep of spacing, length, predication with random masks
        for (int m = 0; m <= MLOG; m++) begin
            for (int len = 0; len <= VLEN; len++) begin
                for (int vm = 0; vm < 2; vm++) begin
                    for (int r = 0; r < 6; r++) begin
                        logic [VLEN-1:0] s, p;
                        s = VLEN'($urandom & $urandom);
                        p = VLEN'($urandom);
                        run_op(mk(vm[0], 5'(r + 1), 5'($urandom), 5'(len)), s, p, len, m,
                               "R3/R4/R5/R6/R7 sweep");
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule